// File: doc/BRIEF.md
# Single-Level Page Table Walker

The block turns a virtual address into a physical address using one flat page table kept in an external memory. The page field in the upper bits of the virtual address picks one table entry. The entry sits at a base address held in a register that software writes. The walker reads the entry through a read port with one cycle of latency. It checks the entry's permission flags against the access type. If the check passes, it places the entry's frame number above the unchanged offset bits of the virtual address. If the check fails, it reports a fault.

Requests arrive on a valid/ready handshake, and each accepted request returns exactly one one-cycle response. The block keeps the entry of its last successful translation. A later access to the same page uses that entry and skips the memory read. Writing the base register counts as a context switch and discards the kept entry.

The default build uses 8-bit addresses: a 2-bit page field, a 6-bit offset and 1-byte entries. In an entry, bits [1:0] hold the frame number, bit 7 is the valid flag, bit 6 permits writes and bit 5 permits instruction fetch. Bits 4..2 are unused.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1 and both `rsp_valid_o` and `mem_re_o` are 0. The kept translation is empty, so the first request always reads the table.
- R2: On a miss, `mem_re_o` is high for exactly one cycle. During that cycle `mem_addr_o` equals the base register plus the page field (bits [7:6] of the VA) times the entry size, which is 1 byte.
- R3: A successful response drives `rsp_pa_o` with the entry's frame (bits [1:0]) in bits [7:6]. Bits [5:0] of `rsp_pa_o` are the VA offset, unchanged.
- R4: An entry whose valid flag (bit 7) is 0 makes the response a fault, with `rsp_fault_o`=1 and `rsp_pa_o`=0.
- R5: The access code on `req_acc_i` selects the permission check: 0 read needs only valid, 1 write also needs bit 6, and 2 fetch also needs bit 5. Code 3 is reserved and always faults.
- R6: A request whose page equals the page of the last successful translation uses no table read. Its response comes one cycle after acceptance.
- R7: A write of the base register discards the kept translation, so the next request reads the table at the new base.
- R8: A faulting translation never loads the kept translation. Another access to the faulting page reads the table again, and the page kept before the fault still hits.
- R9: A request is accepted only while the walker is idle. Each accepted request gives exactly one response pulse. A miss answers three cycles after acceptance, and `req_ready_o` is low while a walk is in progress.
- R10: A hit still checks permissions against the kept entry's flags. A write to a kept read-only page faults and does no table read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_we_i | input | 1 | Write strobe for the table base register |
| base_i | input | 8 | New table base address |
| req_valid_i | input | 1 | Translate request valid |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_va_i | input | 8 | Virtual address |
| req_acc_i | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 reserved |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_fault_o | output | 1 | Response is a fault |
| rsp_pa_o | output | 8 | Physical address (0 on fault) |
| mem_re_o | output | 1 | Table memory read strobe |
| mem_addr_o | output | 8 | Table memory read address |
| mem_rdata_i | input | 8 | Entry data, one cycle after the read strobe |

## Verification
The hardest case to reach is proving that a fault left the kept translation alone. From the ports this shows only as the hit or miss timing of later requests.

The stimulus first loads page 1 into the kept translation. It then faults on page 2. It then returns to page 1, which must still hit in one cycle with no memory read, and then to page 2, which must read the table again.

A permission fault on a kept page, a miss that faults on write but passes on fetch, and a base rewrite are also ordered so that the kept state is visible only through latency and read-strobe counts.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_RESP
  } walk_st_e;

  // flag positions counted down from the entry MSB
  localparam int unsigned FLG_VALID_OFS = 1;
  localparam int unsigned FLG_WRITE_OFS = 2;
  localparam int unsigned FLG_EXEC_OFS  = 3;
endpackage

// File: rtl/pt_perm_check.sv
module pt_perm_check
  import pt_walker_pkg::*;
#(
  parameter int unsigned ENTRY_W = 8
) (
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic [1:0]         acc_i,
  output logic               fault_o
);
  logic vld, wr_ok, ex_ok;

  assign vld   = entry_i[ENTRY_W-FLG_VALID_OFS];
  assign wr_ok = entry_i[ENTRY_W-FLG_WRITE_OFS];
  assign ex_ok = entry_i[ENTRY_W-FLG_EXEC_OFS];

  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_READ:  fault_o = !vld;
      ACC_WRITE: fault_o = !(vld && wr_ok);
      ACC_FETCH: fault_o = !(vld && ex_ok);
      default:   fault_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/pt_last_xlat.sv
module pt_last_xlat #(
  parameter int unsigned PN_W    = 2,
  parameter int unsigned ENTRY_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               inv_i,
  input  logic               ld_i,
  input  logic [PN_W-1:0]    ld_page_i,
  input  logic [ENTRY_W-1:0] ld_entry_i,
  input  logic [PN_W-1:0]    lk_page_i,
  output logic               hit_o,
  output logic               vld_o,
  output logic [PN_W-1:0]    page_o,
  output logic [ENTRY_W-1:0] entry_o
);
  logic               vld_q;
  logic [PN_W-1:0]    page_q;
  logic [ENTRY_W-1:0] entry_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      page_q  <= '0;
      entry_q <= '0;
    end else if (inv_i) begin
      vld_q   <= 1'b0;
    end else if (ld_i) begin
      vld_q   <= 1'b1;
      page_q  <= ld_page_i;
      entry_q <= ld_entry_i;
    end
  end

  assign hit_o   = vld_q && (page_q == lk_page_i);
  assign vld_o   = vld_q;
  assign page_o  = page_q;
  assign entry_o = entry_q;

  // R7: context change empties the kept translation
  a_r7_inv_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i |=> !vld_q);
  a_r6_load_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !inv_i) |=> (vld_q && page_q == $past(ld_page_i)));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned VA_W        = 8,
  parameter int unsigned OFF_W       = 6,
  parameter int unsigned FRAME_W     = 2,
  parameter int unsigned ENTRY_W     = 8,
  parameter int unsigned ENTRY_BYTES = 1,
  parameter int unsigned MEM_AW      = 8,
  localparam int unsigned PN_W       = VA_W - OFF_W,
  localparam int unsigned PA_W       = FRAME_W + OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               base_we_i,
  input  logic [MEM_AW-1:0]  base_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VA_W-1:0]    req_va_i,
  input  logic [1:0]         req_acc_i,
  output logic               rsp_valid_o,
  output logic               rsp_fault_o,
  output logic [PA_W-1:0]    rsp_pa_o,
  output logic               mem_re_o,
  output logic [MEM_AW-1:0]  mem_addr_o,
  input  logic [ENTRY_W-1:0] mem_rdata_i
);
  walk_st_e           state_q, state_d;
  logic [MEM_AW-1:0]  base_q;
  logic [VA_W-1:0]    va_q;
  logic [1:0]         acc_q;
  logic               stale_q;
  logic               fault_q;
  logic [PA_W-1:0]    pa_q;

  logic               accept;
  logic               lx_hit, lx_vld, lx_ld;
  logic [PN_W-1:0]    lx_page;
  logic [ENTRY_W-1:0] lx_entry;
  logic [ENTRY_W-1:0] sel_entry;
  logic [1:0]         sel_acc;
  logic [VA_W-1:0]    sel_va;
  logic               sel_fault;
  logic [PA_W-1:0]    sel_pa;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  pt_last_xlat #(.PN_W(PN_W), .ENTRY_W(ENTRY_W)) i_last (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inv_i     (base_we_i),
    .ld_i      (lx_ld),
    .ld_page_i (va_q[VA_W-1:OFF_W]),
    .ld_entry_i(mem_rdata_i),
    .lk_page_i (req_va_i[VA_W-1:OFF_W]),
    .hit_o     (lx_hit),
    .vld_o     (lx_vld),
    .page_o    (lx_page),
    .entry_o   (lx_entry)
  );

  // idle: hit path from kept entry; wait: returned table entry
  assign sel_entry = (state_q == ST_IDLE) ? lx_entry  : mem_rdata_i;
  assign sel_acc   = (state_q == ST_IDLE) ? req_acc_i : acc_q;
  assign sel_va    = (state_q == ST_IDLE) ? req_va_i  : va_q;

  pt_perm_check #(.ENTRY_W(ENTRY_W)) i_perm (
    .entry_i(sel_entry),
    .acc_i  (sel_acc),
    .fault_o(sel_fault)
  );

  assign sel_pa = sel_fault ? '0 : {sel_entry[FRAME_W-1:0], sel_va[OFF_W-1:0]};

  assign lx_ld = (state_q == ST_WAIT) && !sel_fault && !stale_q && !base_we_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = lx_hit ? ST_RESP : ST_FETCH;
      ST_FETCH: state_d = ST_WAIT;
      ST_WAIT:  state_d = ST_RESP;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      va_q    <= '0;
      acc_q   <= '0;
      stale_q <= 1'b0;
      fault_q <= 1'b0;
      pa_q    <= '0;
    end else begin
      state_q <= state_d;
      if (base_we_i) base_q <= base_i;
      if (accept) begin
        va_q    <= req_va_i;
        acc_q   <= req_acc_i;
        stale_q <= 1'b0;
      end else if (base_we_i && state_q != ST_IDLE) begin
        stale_q <= 1'b1;
      end
      if ((accept && lx_hit) || state_q == ST_WAIT) begin
        fault_q <= sel_fault;
        pa_q    <= sel_pa;
      end
    end
  end

  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_fault_o = rsp_valid_o && fault_q;
  assign rsp_pa_o    = rsp_valid_o ? pa_q : '0;
  assign mem_re_o    = (state_q == ST_FETCH);
  assign mem_addr_o  = base_q + MEM_AW'(va_q[VA_W-1:OFF_W]) * MEM_AW'(ENTRY_BYTES);

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  a_r9_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  a_r2_one_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> !mem_re_o);
  a_r8_fault_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o && !$past(base_we_i)) |-> ($stable(lx_vld) && $stable(lx_page)));
  a_r3_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> rsp_pa_o[OFF_W-1:0] == va_q[OFF_W-1:0]);
  a_r4_fault_zero_pa: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> rsp_pa_o == '0);
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_we = 1'b0;
  logic [7:0] base = '0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] req_va = '0;
  logic [1:0] req_acc = '0;
  logic       rsp_valid, rsp_fault;
  logic [7:0] rsp_pa;
  logic       mem_re;
  logic [7:0] mem_addr;
  logic [7:0] mem_rdata = '0;
  logic [7:0] mem [256];

  int n_chk = 0, n_bad = 0;
  logic [7:0] cur_base = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker i_pt_walker (
    .clk_i(clk), .rst_ni(rst_n),
    .base_we_i(base_we), .base_i(base),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_va_i(req_va), .req_acc_i(req_acc),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_pa_o(rsp_pa),
    .mem_re_o(mem_re), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata)
  );

  always_ff @(posedge clk) if (mem_re) mem_rdata <= mem[mem_addr];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_base(input logic [7:0] b);
    @(negedge clk); base_we = 1'b1; base = b;
    @(negedge clk); base_we = 1'b0;
    cur_base = b;
  endtask

  task automatic xlate(input logic [7:0] va, input logic [1:0] acc, input bit exp_f,
                       input logic [7:0] exp_pa, input bit exp_hit, input string tag);
    int lat = 0, rd = 0;
    logic [7:0] seen = '0;
    logic [7:0] exp_addr;
    exp_addr = cur_base + {6'd0, va[7:6]};
    @(negedge clk);
    check(req_ready, {tag, " ready idle R9"}, int'(req_ready), 1);
    req_va = va; req_acc = acc; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0; lat = 1;
    while (!rsp_valid && lat < 10) begin
      if (mem_re) begin rd++; seen = mem_addr; end
      if (lat == 1) check(!req_ready, {tag, " busy R9"}, int'(req_ready), 0);
      @(negedge clk); lat++;
    end
    check(lat == (exp_hit ? 1 : 3), {tag, " latency R6/R9"}, lat, exp_hit ? 1 : 3);
    check(rd == (exp_hit ? 0 : 1), {tag, " table reads R2/R6"}, rd, exp_hit ? 0 : 1);
    if (!exp_hit) check(seen == exp_addr, {tag, " entry address R2"}, int'(seen), int'(exp_addr));
    check(rsp_fault == exp_f, {tag, " fault R4/R5"}, int'(rsp_fault), int'(exp_f));
    check(rsp_pa == (exp_f ? 8'h00 : exp_pa), {tag, " phys addr R3"}, int'(rsp_pa),
          int'(exp_f ? 8'h00 : exp_pa));
  endtask

  // {va, acc, fault, pa, hit}
  localparam logic [19:0] VECS [0:10] = '{
    {8'h05, 2'd0, 1'b0, 8'h85, 1'b0},  // R3 miss page0
    {8'h3F, 2'd1, 1'b0, 8'hBF, 1'b1},  // R6 hit write
    {8'h10, 2'd2, 1'b0, 8'h90, 1'b1},  // R6 hit fetch
    {8'h41, 2'd0, 1'b0, 8'hC1, 1'b0},  // R2 miss page1
    {8'h42, 2'd1, 1'b1, 8'h00, 1'b1},  // R10 hit, no write permit
    {8'h80, 2'd0, 1'b1, 8'h00, 1'b0},  // R4 invalid entry
    {8'h47, 2'd0, 1'b0, 8'hC7, 1'b1},  // R8 page1 still kept
    {8'h81, 2'd0, 1'b1, 8'h00, 1'b0},  // R8 page2 not kept
    {8'hC2, 2'd1, 1'b1, 8'h00, 1'b0},  // R5 write denied
    {8'hC2, 2'd2, 1'b0, 8'h02, 1'b0},  // R5 fetch permitted
    {8'hC3, 2'd3, 1'b1, 8'h00, 1'b1}   // R5 reserved code
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h20] = 8'hE2;  // page0 frame2 V W X
    mem[8'h21] = 8'h83;  // page1 frame3 V
    mem[8'h22] = 8'h01;  // page2 invalid
    mem[8'h23] = 8'hA0;  // page3 frame0 V X
    mem[8'h43] = 8'h81;  // alt page3 frame1 V

    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 no response in reset", int'(rsp_valid), 0);
    check(mem_re == 1'b0, "R1 no read in reset", int'(mem_re), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && !rsp_valid && !mem_re, "R1 idle after release", 0, 0);

    set_base(8'h20);
    for (int i = 0; i < 11; i++) begin
      xlate(VECS[i][19:12], VECS[i][11:10], VECS[i][9], VECS[i][8:1], VECS[i][0],
            $sformatf("vec%0d", i));
    end

    // R7: base rewrite drops the kept page3 entry
    set_base(8'h40);
    xlate(8'hC4, 2'd0, 1'b0, 8'h44, 1'b0, "R7 new base miss");
    xlate(8'hC5, 2'd0, 1'b0, 8'h45, 1'b1, "R7 new context hit");

    // R1: reset empties the kept translation
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; cur_base = 8'h00;
    mem[8'h03] = 8'hC1;
    xlate(8'hC6, 2'd1, 1'b0, 8'h46, 1'b0, "R1 miss after reset");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule